// File: doc/BRIEF.md
# Delayed-Read Request Tracker

This block follows a single outstanding delayed read on a bus target. When a master issues a read and the tracker is free, the address and command are captured and the master is told to retry. The tracker then asks a slow back-end for the data. Once the data is back, it waits for the master to repeat exactly the same request. That repeat completes the read and frees the tracker. While the read is outstanding, any other request is sent away with a retry.

A programmable discard counter limits how long fetched data may wait for the master. It is loaded from a preload register when the data arrives and counts down once per clock. If it reaches zero first, the data is thrown away and a sticky status flag is raised. The flag warns software that a read with side effects may have been carried out without its result ever being delivered. A control bit selects the policy for mismatching requests that arrive after the data is ready: either drop the pending read at once, or keep it until the original master returns or the counter runs out. A second control bit decides whether the sticky flag drives the interrupt output.

Top module: `dread_tracker`

## Requirements
- R1: A request with `req_read`=1 that arrives while nothing is pending gets `rsp_retry`=1 in that cycle. From the next cycle on, `pending` and `fetch_req` are 1, and `fetch_addr`/`fetch_cmd` hold the captured address and command.
- R2: While the back-end fetch is outstanding (`fetch_req`=1), every request gets `rsp_retry`=1 and `rsp_done`=0, whether or not it matches the captured request.
- R3: The clock edge that sees `fetch_ack`=1 during a fetch loads `tmr_count` with `pre_rdata`. After that, `tmr_count` falls by exactly one per clock while the data waits and the count is above zero.
- R4: While the data waits and `tmr_count` is not zero, a request whose address and command both equal the captured ones gets `rsp_done`=1 and `rsp_retry`=0 in that cycle, with `rsp_data` equal to the fetched word. `pending` is 0 from the next cycle.
- R5: While the data waits and `tmr_count` is zero, the read is dropped. Any request in that cycle, including a matching one, gets `rsp_retry`=1 and `rsp_done`=0. From the next cycle, `pending`=0 and `discard_sts`=1.
- R6: With the hold bit clear (`ctrl_wdata` bit 0 = 0), a non-matching request while the data waits gets `rsp_retry`=1, and the pending read is dropped (`pending`=0 next cycle) without setting `discard_sts`.
- R7: With the hold bit set (`ctrl_wdata` bit 0 = 1), non-matching requests while the data waits get `rsp_retry`=1 and `pending` stays 1. A later matching request still completes the read.
- R8: A cycle with `sts_w1c`=1 clears `discard_sts` at the next edge. A timeout in that same cycle wins, and `discard_sts` stays 1.
- R9: `discard_irq` is 1 exactly when `discard_sts` is 1 and the interrupt-enable bit (`ctrl_wdata` bit 1) is set.
- R10: After reset, `pending`, `discard_sts`, `discard_irq` and `ctrl_rdata` are 0, and `pre_rdata` equals the PRELOAD_RST parameter (32 by default).
- R11: A cycle with `pre_we`=1 writes `pre_wdata` into the preload register, which reads back on `pre_rdata` from the next cycle.
- R12: A request with `req_read`=0 while nothing is pending is ignored by the tracker: `rsp_retry`=0, `rsp_done`=0, and `pending` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A master request is present this cycle |
| req_read | input | 1 | The request is a read (eligible to be captured) |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command code |
| rsp_retry | output | 1 | Tell the master to retry this request |
| rsp_done | output | 1 | Request completes with `rsp_data` |
| rsp_data | output | DATA_W | Fetched read data |
| fetch_req | output | 1 | Back-end fetch outstanding |
| fetch_addr | output | ADDR_W | Captured address for the back-end |
| fetch_cmd | output | CMD_W | Captured command for the back-end |
| fetch_ack | input | 1 | Back-end returns data this cycle |
| fetch_data | input | DATA_W | Back-end data |
| pending | output | 1 | A delayed read is being tracked |
| pre_we | input | 1 | Write strobe for the preload register |
| pre_wdata | input | TMR_W | Preload write value |
| pre_rdata | output | TMR_W | Preload register readback |
| tmr_count | output | TMR_W | Current discard count |
| ctrl_we | input | 1 | Write strobe for control bits |
| ctrl_wdata | input | 2 | Bit 0 hold mode, bit 1 interrupt enable |
| ctrl_rdata | output | 2 | Control readback, same layout |
| sts_w1c | input | 1 | Write-one-to-clear for the discard flag |
| discard_sts | output | 1 | Sticky discard-on-timeout flag |
| discard_irq | output | 1 | Interrupt output |

## Verification
Two pairs of functions can land on the same clock. The first pair is a timeout and a software clear of the sticky flag. The bench sets a preload of 1 so that it knows the expiry cycle exactly, pulses `sts_w1c` in that cycle, and expects the flag to stay set. The second pair is a timeout and a matching retry. The bench lets the count reach zero, presents the original request in that cycle, and expects a retry rather than a completion, with the tracker free afterwards.

// File: rtl/dread_pkg.sv
package dread_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2
    } dr_state_e;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_IRQ_BIT  = 1;
endpackage

// File: rtl/dread_match.sv
module dread_match #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              cmp_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CMD_W-1:0]  in_cmd,
    output logic              hit,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [CMD_W-1:0]  lat_cmd
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } tag_t;

    tag_t tag_d, tag_q;

    always_comb begin
        tag_d = tag_q;
        if (capture) begin
            tag_d.addr = in_addr;
            tag_d.cmd  = in_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign hit      = cmp_valid && (in_addr == tag_q.addr) && (in_cmd == tag_q.cmd);
    assign lat_addr = tag_q.addr;
    assign lat_cmd  = tag_q.cmd;

    // R1: a capture must be visible on the latched tag one edge later
    a_r1_tag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (lat_addr == $past(in_addr)) && (lat_cmd == $past(in_cmd)));
endmodule

// File: rtl/dread_timer.sv
module dread_timer #(
    parameter int              TMR_W       = 16,
    parameter logic [TMR_W-1:0] PRELOAD_RST = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_we,
    input  logic [TMR_W-1:0] pre_wdata,
    input  logic             load,
    input  logic             run,
    output logic [TMR_W-1:0] preload_q,
    output logic [TMR_W-1:0] count_q,
    output logic             zero
);
    typedef struct packed {
        logic [TMR_W-1:0] pre;
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (pre_we) t_d.pre = pre_wdata;
        if (load) begin
            t_d.cnt = t_q.pre;
        end else if (run && (t_q.cnt != '0)) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.pre <= PRELOAD_RST;
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign preload_q = t_q.pre;
    assign count_q   = t_q.cnt;
    assign zero      = (t_q.cnt == '0);

    a_r3_load_preload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(preload_q)));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

    a_r11_preload_write: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> (preload_q == $past(pre_wdata)));
endmodule

// File: rtl/dread_ctrl.sv
module dread_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_wdata,
    input  logic       clr_w1c,
    input  logic       set_discard,
    output logic       hold_q,
    output logic       irqen_q,
    output logic       sticky_q,
    output logic       irq
);
    import dread_pkg::*;

    typedef struct packed {
        logic hold;
        logic irqen;
        logic sticky;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ctrl_we) begin
            c_d.hold  = ctrl_wdata[CTRL_HOLD_BIT];
            c_d.irqen = ctrl_wdata[CTRL_IRQ_BIT];
        end
        if (set_discard)  c_d.sticky = 1'b1;
        else if (clr_w1c) c_d.sticky = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hold_q   = c_q.hold;
    assign irqen_q  = c_q.irqen;
    assign sticky_q = c_q.sticky;
    assign irq      = c_q.sticky && c_q.irqen;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_discard |=> sticky_q);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w1c && !set_discard) |=> !sticky_q);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irqen_q |-> !irq);
endmodule

// File: rtl/dread_tracker.sv
module dread_tracker #(
    parameter int               ADDR_W      = 32,
    parameter int               CMD_W       = 4,
    parameter int               DATA_W      = 32,
    parameter int               TMR_W       = 16,
    parameter logic [TMR_W-1:0] PRELOAD_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    output logic              rsp_retry,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [CMD_W-1:0]  fetch_cmd,
    input  logic              fetch_ack,
    input  logic [DATA_W-1:0] fetch_data,
    output logic              pending,
    input  logic              pre_we,
    input  logic [TMR_W-1:0]  pre_wdata,
    output logic [TMR_W-1:0]  pre_rdata,
    output logic [TMR_W-1:0]  tmr_count,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_wdata,
    output logic [1:0]        ctrl_rdata,
    input  logic              sts_w1c,
    output logic              discard_sts,
    output logic              discard_irq
);
    import dread_pkg::*;

    typedef struct packed {
        dr_state_e         st;
        logic [DATA_W-1:0] data;
    } trk_t;

    trk_t cur_q, nxt_d;

    logic hit, capture, load, set_disc, tmr_zero, hold_q, irqen_q;

    dread_match #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .cmp_valid (req_valid),
        .in_addr   (req_addr),
        .in_cmd    (req_cmd),
        .hit       (hit),
        .lat_addr  (fetch_addr),
        .lat_cmd   (fetch_cmd)
    );

    dread_timer #(.TMR_W(TMR_W), .PRELOAD_RST(PRELOAD_RST)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (pre_we),
        .pre_wdata (pre_wdata),
        .load      (load),
        .run       (cur_q.st == ST_READY),
        .preload_q (pre_rdata),
        .count_q   (tmr_count),
        .zero      (tmr_zero)
    );

    dread_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .clr_w1c     (sts_w1c),
        .set_discard (set_disc),
        .hold_q      (hold_q),
        .irqen_q     (irqen_q),
        .sticky_q    (discard_sts),
        .irq         (discard_irq)
    );

    always_comb begin
        nxt_d     = cur_q;
        rsp_retry = 1'b0;
        rsp_done  = 1'b0;
        capture   = 1'b0;
        load      = 1'b0;
        set_disc  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid && req_read) begin
                    capture   = 1'b1;
                    rsp_retry = 1'b1;
                    nxt_d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                rsp_retry = req_valid;
                if (fetch_ack) begin
                    load       = 1'b1;
                    nxt_d.data = fetch_data;
                    nxt_d.st   = ST_READY;
                end
            end
            ST_READY: begin
                if (tmr_zero) begin
                    set_disc  = 1'b1;
                    rsp_retry = req_valid;
                    nxt_d.st  = ST_IDLE;
                end else if (hit) begin
                    rsp_done = 1'b1;
                    nxt_d.st = ST_IDLE;
                end else if (req_valid) begin
                    rsp_retry = 1'b1;
                    if (!hold_q) nxt_d.st = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.data <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rsp_data   = cur_q.data;
    assign fetch_req  = (cur_q.st == ST_FETCH);
    assign pending    = (cur_q.st != ST_IDLE);
    assign ctrl_rdata = {irqen_q, hold_q};

    a_r1_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && req_valid && req_read) |=> (fetch_req && (fetch_addr == $past(req_addr))));

    a_r2_retry_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && req_valid) |-> (rsp_retry && !rsp_done));

    a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !pending);

    a_r4_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_retry, rsp_done}));

    a_r5_expiry_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_READY) && tmr_zero) |=> (!pending && discard_sts));

    a_r6_mismatch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_READY) && !tmr_zero && req_valid && !hit && !hold_q) |=> !pending);

    a_r7_mismatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.st == ST_READY) && !tmr_zero && req_valid && !hit && hold_q) |=> pending);

    a_r12_idle_nonread: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && req_valid && !req_read) |-> (!rsp_retry && !rsp_done));
endmodule

// File: tb/dread_tracker_tb_top.sv
`timescale 1ns/1ps
module dread_tracker_tb_top;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam int DATA_W = 32;
    localparam int TMR_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_read;
    logic [ADDR_W-1:0] req_addr;
    logic [CMD_W-1:0]  req_cmd;
    logic              rsp_retry, rsp_done;
    logic [DATA_W-1:0] rsp_data;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic [CMD_W-1:0]  fetch_cmd;
    logic              fetch_ack;
    logic [DATA_W-1:0] fetch_data;
    logic              pending;
    logic              pre_we;
    logic [TMR_W-1:0]  pre_wdata, pre_rdata, tmr_count;
    logic              ctrl_we;
    logic [1:0]        ctrl_wdata, ctrl_rdata;
    logic              sts_w1c, discard_sts, discard_irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dread_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr), .req_cmd(req_cmd),
        .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_cmd(fetch_cmd),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .pending(pending),
        .pre_we(pre_we), .pre_wdata(pre_wdata), .pre_rdata(pre_rdata), .tmr_count(tmr_count),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .sts_w1c(sts_w1c), .discard_sts(discard_sts), .discard_irq(discard_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_req(input logic v, input logic rd, input logic [ADDR_W-1:0] a,
                             input logic [CMD_W-1:0] c);
        req_valid = v; req_read = rd; req_addr = a; req_cmd = c;
        #1;
    endtask

    task automatic idle_req();
        drive_req(1'b0, 1'b0, '0, '0);
    endtask

    task automatic write_pre(input logic [TMR_W-1:0] v);
        pre_we = 1'b1; pre_wdata = v;
        step();
        pre_we = 1'b0;
        #1;
        check("R11 preload readback", 64'(pre_rdata), 64'(v));
    endtask

    task automatic write_ctrl(input logic [1:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        step();
        ctrl_we = 1'b0;
        #1;
    endtask

    task automatic start_read(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c);
        drive_req(1'b1, 1'b1, a, c);
        check("R1 retry on capture", 64'(rsp_retry), 64'd1);
        step();
        idle_req();
        check("R1 pending", 64'(pending), 64'd1);
        check("R1 fetch_req", 64'(fetch_req), 64'd1);
        check("R1 fetch_addr", 64'(fetch_addr), 64'(a));
        check("R1 fetch_cmd", 64'(fetch_cmd), 64'(c));
    endtask

    task automatic deliver(input logic [DATA_W-1:0] d, input logic [TMR_W-1:0] exp_cnt);
        fetch_ack = 1'b1; fetch_data = d;
        step();
        fetch_ack = 1'b0;
        #1;
        check("R3 count loaded", 64'(tmr_count), 64'(exp_cnt));
    endtask

    task automatic t_reset();
        check("R10 pending", 64'(pending), 64'd0);
        check("R10 sticky", 64'(discard_sts), 64'd0);
        check("R10 irq", 64'(discard_irq), 64'd0);
        check("R10 ctrl", 64'(ctrl_rdata), 64'd0);
        check("R10 preload", 64'(pre_rdata), 64'd32);
    endtask

    task automatic t_ignore_nonread();
        drive_req(1'b1, 1'b0, 32'h1000, 4'h7);
        check("R12 no retry", 64'(rsp_retry), 64'd0);
        check("R12 no done", 64'(rsp_done), 64'd0);
        step();
        idle_req();
        check("R12 still idle", 64'(pending), 64'd0);
    endtask

    task automatic t_basic();
        write_pre(16'd5);
        start_read(32'hA0, 4'h6);
        drive_req(1'b1, 1'b1, 32'hB0, 4'h6);
        check("R2 other retry", 64'(rsp_retry), 64'd1);
        check("R2 other no done", 64'(rsp_done), 64'd0);
        step();
        drive_req(1'b1, 1'b1, 32'hA0, 4'h6);
        check("R2 same retry", 64'(rsp_retry), 64'd1);
        check("R2 same no done", 64'(rsp_done), 64'd0);
        step();
        idle_req();
        check("R2 still fetching", 64'(fetch_req), 64'd1);
        deliver(32'hDEAD_BEEF, 16'd5);
        step();
        check("R3 count step", 64'(tmr_count), 64'd4);
        drive_req(1'b1, 1'b1, 32'hA0, 4'h7);
        check("R4 cmd mismatch retried", 64'(rsp_retry), 64'd1);
        drive_req(1'b1, 1'b1, 32'hA0, 4'h6);
        check("R4 done", 64'(rsp_done), 64'd1);
        check("R4 no retry", 64'(rsp_retry), 64'd0);
        check("R4 data", 64'(rsp_data), 64'hDEAD_BEEF);
        step();
        idle_req();
        check("R4 freed", 64'(pending), 64'd0);
    endtask

    task automatic t_timeout();
        write_ctrl(2'b10);
        write_pre(16'd3);
        start_read(32'hC4, 4'h6);
        deliver(32'h1234_5678, 16'd3);
        step();
        step();
        step();
        check("R3 count at zero", 64'(tmr_count), 64'd0);
        drive_req(1'b1, 1'b1, 32'hC4, 4'h6);
        check("R5 expiry retry", 64'(rsp_retry), 64'd1);
        check("R5 expiry no done", 64'(rsp_done), 64'd0);
        step();
        idle_req();
        check("R5 dropped", 64'(pending), 64'd0);
        check("R5 sticky set", 64'(discard_sts), 64'd1);
        check("R9 irq enabled", 64'(discard_irq), 64'd1);
        sts_w1c = 1'b1;
        step();
        sts_w1c = 1'b0;
        #1;
        check("R8 cleared", 64'(discard_sts), 64'd0);
        check("R9 irq low", 64'(discard_irq), 64'd0);
    endtask

    task automatic t_nohold();
        write_pre(16'd8);
        start_read(32'hD0, 4'h6);
        deliver(32'h0000_00AA, 16'd8);
        drive_req(1'b1, 1'b0, 32'hE0, 4'h3);
        check("R6 mismatch retry", 64'(rsp_retry), 64'd1);
        step();
        idle_req();
        check("R6 dropped", 64'(pending), 64'd0);
        check("R6 no sticky", 64'(discard_sts), 64'd0);
    endtask

    task automatic t_hold();
        write_ctrl(2'b01);
        check("R7 ctrl readback", 64'(ctrl_rdata), 64'd1);
        write_pre(16'd10);
        start_read(32'hF0, 4'h6);
        deliver(32'hCAFE_0001, 16'd10);
        for (int i = 0; i < 3; i++) begin
            drive_req(1'b1, 1'b1, 32'h100 + 32'(i), 4'h6);
            check("R7 hold retry", 64'(rsp_retry), 64'd1);
            step();
            idle_req();
            check("R7 kept", 64'(pending), 64'd1);
        end
        drive_req(1'b1, 1'b1, 32'hF0, 4'h6);
        check("R7 late done", 64'(rsp_done), 64'd1);
        check("R7 late data", 64'(rsp_data), 64'hCAFE_0001);
        step();
        idle_req();
        check("R7 freed", 64'(pending), 64'd0);
        write_pre(16'd2);
        start_read(32'h44, 4'h2);
        deliver(32'h5, 16'd2);
        for (int i = 0; i < 3; i++) begin
            drive_req(1'b1, 1'b1, 32'h88, 4'h2);
            check("R7 retry until expiry", 64'(rsp_retry), 64'd1);
            step();
        end
        idle_req();
        check("R5 hold expiry drops", 64'(pending), 64'd0);
        check("R5 hold expiry sticky", 64'(discard_sts), 64'd1);
        check("R9 irq masked", 64'(discard_irq), 64'd0);
    endtask

    task automatic t_collide();
        write_pre(16'd1);
        sts_w1c = 1'b1;
        step();
        sts_w1c = 1'b0;
        #1;
        check("R8 pre-clear", 64'(discard_sts), 64'd0);
        start_read(32'h20, 4'h6);
        deliver(32'h9, 16'd1);
        step();
        check("R3 reached zero", 64'(tmr_count), 64'd0);
        sts_w1c = 1'b1;
        step();
        sts_w1c = 1'b0;
        #1;
        check("R8 set beats clear", 64'(discard_sts), 64'd1);
        sts_w1c = 1'b1;
        step();
        sts_w1c = 1'b0;
        #1;
        check("R8 clear alone", 64'(discard_sts), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_read = 1'b0; req_addr = '0; req_cmd = '0;
        fetch_ack = 1'b0; fetch_data = '0;
        pre_we = 1'b0; pre_wdata = '0;
        ctrl_we = 1'b0; ctrl_wdata = '0;
        sts_w1c = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ignore_nonread();
        t_basic();
        t_timeout();
        t_nohold();
        t_hold();
        t_collide();
        step();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule